// File: doc/BRIEF.md
# ModRM/SIB Effective Address Generator

This block turns the addressing fields of a decoded instruction into a memory effective address. It takes the ModRM byte, an optional SIB byte, the two register-extension bits, the raw displacement bytes, a bank of sixteen 64-bit general registers, the address of the following instruction and a flag for the 64-bit mode. From these it picks a base term, a scaled index term and a sign-extended displacement, and it adds them.

Two encodings depend on the mode. With mod=00 and r/m=101, 64-bit mode adds the displacement to the next-instruction address. Compatibility mode uses the same encoding for a plain 32-bit absolute address. The SIB no-base form (mod=00, base=101) gives an absolute 32-bit displacement in both modes, so it is the only absolute form left in 64-bit mode. The block also reports whether the address is relative to the instruction pointer, how many displacement bytes the encoding needs, and whether the operand is a register and has no address. With the default parameters the results pass through one output register.

Top module: `ea_gen`

## Requirements
- R1: While rst_n is low, with OUT_REG=1 (the default), every output reads zero.
- R2: mod=11 (modrm[7:6]) sets reg_operand=1, ea=0, rip_rel=0 and disp_size=0.
- R3: With r/m (modrm[2:0]) not 100, and not the mod=00/r/m=101 case, ea is register {rex_b, r/m} plus the displacement. For mod=01 this is disp[7:0] sign-extended and disp_size=1. For mod=10 this is disp[31:0] sign-extended and disp_size=2. For mod=00 there is no displacement and disp_size=0.
- R4: r/m=100 with mod not 11 selects the SIB form. The base register is {rex_b, sib[2:0]}. The index register {rex_x, sib[5:3]} is shifted left by sib[7:6] (factor 1, 2, 4 or 8). An index code of 0100 adds no index, while code 1100 (register 12) is a valid index.
- R5: In the SIB form with mod=00 and sib[2:0]=101, there is no base register, whatever rex_b is. The sign-extended disp[31:0] is added instead and disp_size=2. This holds in both modes.
- R6: In 64-bit mode (long_mode=1), mod=00 with r/m=101 gives ea = next_ip + sign-extended disp[31:0], rip_rel=1 and disp_size=2.
- R7: In compatibility mode (long_mode=0), mod=00 with r/m=101 gives ea = disp[31:0] zero-extended, rip_rel=0 and disp_size=2.
- R8: In compatibility mode, rex_b and rex_x are ignored, ea[63:32] is zero, and ea[31:0] is the 32-bit wrapped sum.
- R9: In 64-bit mode, the sum of all terms wraps modulo 2^64.
- R10: With OUT_REG=1, the outputs show the result of the inputs sampled at the previous rising clock edge. Between edges the outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| long_mode | input | 1 | 1 = 64-bit mode, 0 = compatibility mode |
| rex_b | input | 1 | Extension bit for the base or r/m register number |
| rex_x | input | 1 | Extension bit for the SIB index register number |
| modrm | input | 8 | ModRM byte: mod [7:6], reg [5:3], r/m [2:0] |
| sib | input | 8 | SIB byte: scale [7:6], index [5:3], base [2:0] |
| disp | input | 32 | Raw displacement bytes, low byte first |
| next_ip | input | 64 | Address of the following instruction |
| regs_flat | input | 1024 | Sixteen 64-bit registers; register n is in bits [64n+63:64n] |
| ea | output | 64 | Effective address |
| rip_rel | output | 1 | Address is relative to next_ip |
| disp_size | output | 2 | Displacement bytes the encoding needs: 0, 1 or 2 (meaning 4 bytes) |
| reg_operand | output | 1 | Operand is a register and has no address |

## Verification
The assertions assume that the inputs are settled before each rising clock edge and that long_mode is a clean level, because they check the combinational result against the decoded fields at that edge. They also assume that no displacement-size code other than 0, 1 or 2 can come out. The stimulus drives every input on the falling edge only. It draws ModRM, SIB, extension bits, mode, displacement, next address and register contents from a seeded $urandom stream, so every field combination, including the no-base, no-index and relative cases, stays within the legal byte encodings. Directed cases then pin down the sign-extension edges, wraparound and mode-specific encodings.

// File: rtl/ea_pkg.sv
// Package ea_pkg: shared types and small helpers for the effective address
// generator. Assumes a 64-bit address path and a 32-bit compatibility path.
package ea_pkg;

    // Displacement size code as seen on the disp_size output.
    typedef enum logic [1:0] {
        DSZ_NONE  = 2'd0,
        DSZ_BYTE  = 2'd1,
        DSZ_DWORD = 2'd2
    } dsz_e;

    // Decoded addressing controls produced from ModRM/SIB.
    typedef struct packed {
        logic       is_reg;
        logic       use_rip;
        logic       use_base;
        logic [3:0] base_sel;
        logic       use_index;
        logic [3:0] index_sel;
        logic [1:0] scale;
        dsz_e       dsz;
    } ea_ctl_t;

    localparam logic [1:0] MOD_NODISP = 2'b00;
    localparam logic [1:0] MOD_DISP8  = 2'b01;
    localparam logic [1:0] MOD_DISP32 = 2'b10;
    localparam logic [1:0] MOD_REG    = 2'b11;
    localparam logic [2:0] RM_SIB     = 3'b100;
    localparam logic [2:0] RM_SPECIAL = 3'b101;
    localparam logic [3:0] IDX_NONE   = 4'b0100;

endpackage

// File: rtl/ea_field_decode.sv
// ea_field_decode: turns ModRM, SIB and extension bits into addressing
// controls. Assumes the SIB byte is only meaningful when r/m selects it;
// extension bits are dropped outside 64-bit mode.
module ea_field_decode
    import ea_pkg::*;
(
    input  logic       long_mode,
    input  logic       rex_b,
    input  logic       rex_x,
    input  logic [7:0] modrm,
    input  logic [7:0] sib,
    output ea_ctl_t    ctl
);

    logic [1:0] md;
    logic [2:0] rm;
    logic       xb;
    logic       xx;

    // Split fields and gate extension bits by mode.
    always_comb begin
        md = modrm[7:6];
        rm = modrm[2:0];
        xb = rex_b & long_mode;
        xx = rex_x & long_mode;
    end

    // Select base, index, scale and displacement size per encoding.
    always_comb begin
        ctl           = '0;
        ctl.dsz       = DSZ_NONE;
        ctl.base_sel  = {xb, rm};
        ctl.index_sel = {xx, sib[5:3]};
        ctl.scale     = sib[7:6];
        case (md)
            MOD_DISP8:  ctl.dsz = DSZ_BYTE;
            MOD_DISP32: ctl.dsz = DSZ_DWORD;
            default:    ctl.dsz = DSZ_NONE;
        endcase
        if (md == MOD_REG) begin
            ctl.is_reg = 1'b1;
            ctl.dsz    = DSZ_NONE;
        end else if (rm == RM_SIB) begin
            ctl.use_index = (ctl.index_sel != IDX_NONE);
            ctl.base_sel  = {xb, sib[2:0]};
            if (md == MOD_NODISP && sib[2:0] == RM_SPECIAL) begin
                ctl.use_base = 1'b0;
                ctl.dsz      = DSZ_DWORD;
            end else begin
                ctl.use_base = 1'b1;
            end
        end else if (md == MOD_NODISP && rm == RM_SPECIAL) begin
            ctl.use_rip = long_mode;
            ctl.dsz     = DSZ_DWORD;
        end else begin
            ctl.use_base = 1'b1;
        end
    end

endmodule

// File: rtl/ea_operand_mux.sv
// ea_operand_mux: unpacks the flat register bank and reads the base and
// index registers named by the decoder. Assumes NREG entries of XLEN bits.
module ea_operand_mux #(
    parameter int XLEN = 64,
    parameter int NREG = 16,
    localparam int SELW = $clog2(NREG)
) (
    input  logic [NREG*XLEN-1:0] regs_flat,
    input  logic [SELW-1:0]      base_sel,
    input  logic [SELW-1:0]      index_sel,
    output logic [XLEN-1:0]      base_val,
    output logic [XLEN-1:0]      index_val
);

    logic [XLEN-1:0] bank [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_unpack
        assign bank[i] = regs_flat[i*XLEN +: XLEN];
    end

    // Read both ports of the register bank.
    always_comb begin
        base_val  = bank[base_sel];
        index_val = bank[index_sel];
    end

endmodule

// File: rtl/ea_adder.sv
// ea_adder: forms the three address terms and adds them. Assumes the
// displacement arrives as raw bytes; sign extension follows the size code.
// The sum wraps at XLEN bits, or at CLEN bits outside 64-bit mode.
module ea_adder
    import ea_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int CLEN = 32,
    parameter int DLEN = 32
) (
    input  logic            long_mode,
    input  ea_ctl_t         ctl,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] index_val,
    input  logic [XLEN-1:0] next_ip,
    input  logic [DLEN-1:0] disp,
    output logic [XLEN-1:0] ea
);

    logic [XLEN-1:0] t_base;
    logic [XLEN-1:0] t_index;
    logic [XLEN-1:0] t_disp;
    logic [XLEN-1:0] sum;

    // Choose base term: next-instruction address, register or zero.
    always_comb begin
        if (ctl.use_rip)       t_base = next_ip;
        else if (ctl.use_base) t_base = base_val;
        else                   t_base = '0;
    end

    // Scale the index register by a left shift.
    always_comb begin
        t_index = ctl.use_index ? (index_val << ctl.scale) : '0;
    end

    // Sign-extend the displacement to the address width.
    always_comb begin
        case (ctl.dsz)
            DSZ_BYTE:  t_disp = {{(XLEN-8){disp[7]}}, disp[7:0]};
            DSZ_DWORD: t_disp = {{(XLEN-DLEN){disp[DLEN-1]}}, disp};
            default:   t_disp = '0;
        endcase
    end

    // Add terms and truncate outside 64-bit mode.
    always_comb begin
        sum = t_base + t_index + t_disp;
        if (ctl.is_reg) sum = '0;
        if (!long_mode) sum[XLEN-1:CLEN] = '0;
        ea = sum;
    end

endmodule

// File: rtl/ea_gen.sv
// ea_gen: top of the effective address generator. Decodes ModRM/SIB,
// reads the register bank, adds the terms and optionally registers the
// results (OUT_REG=1 gives one cycle of latency). Assumes inputs are
// stable around the rising clock edge.
module ea_gen
    import ea_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int CLEN    = 32,
    parameter int NREG    = 16,
    parameter int DLEN    = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 long_mode,
    input  logic                 rex_b,
    input  logic                 rex_x,
    input  logic [7:0]           modrm,
    input  logic [7:0]           sib,
    input  logic [DLEN-1:0]      disp,
    input  logic [XLEN-1:0]      next_ip,
    input  logic [NREG*XLEN-1:0] regs_flat,
    output logic [XLEN-1:0]      ea,
    output logic                 rip_rel,
    output logic [1:0]           disp_size,
    output logic                 reg_operand
);

    ea_ctl_t         ctl;
    logic [XLEN-1:0] base_val;
    logic [XLEN-1:0] index_val;
    logic [XLEN-1:0] ea_nxt;
    logic            rip_nxt;
    logic [1:0]      dsz_nxt;
    logic            reg_nxt;

    ea_field_decode u_dec (
        .long_mode (long_mode),
        .rex_b     (rex_b),
        .rex_x     (rex_x),
        .modrm     (modrm),
        .sib       (sib),
        .ctl       (ctl)
    );

    ea_operand_mux #(.XLEN(XLEN), .NREG(NREG)) u_mux (
        .regs_flat (regs_flat),
        .base_sel  (ctl.base_sel),
        .index_sel (ctl.index_sel),
        .base_val  (base_val),
        .index_val (index_val)
    );

    ea_adder #(.XLEN(XLEN), .CLEN(CLEN), .DLEN(DLEN)) u_add (
        .long_mode (long_mode),
        .ctl       (ctl),
        .base_val  (base_val),
        .index_val (index_val),
        .next_ip   (next_ip),
        .disp      (disp),
        .ea        (ea_nxt)
    );

    // Collect side outputs from the decoded controls.
    always_comb begin
        rip_nxt = ctl.use_rip;
        dsz_nxt = ctl.dsz;
        reg_nxt = ctl.is_reg;
    end

    if (OUT_REG) begin : g_reg
        // Register all results; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ea          <= '0;
                rip_rel     <= 1'b0;
                disp_size   <= 2'd0;
                reg_operand <= 1'b0;
            end else begin
                ea          <= ea_nxt;
                rip_rel     <= rip_nxt;
                disp_size   <= dsz_nxt;
                reg_operand <= reg_nxt;
            end
        end
    end else begin : g_comb
        assign ea          = ea_nxt;
        assign rip_rel     = rip_nxt;
        assign disp_size   = dsz_nxt;
        assign reg_operand = reg_nxt;
    end

endmodule

// File: rtl/ea_checker.sv
// ea_checker: properties for ea_gen, attached with bind. Relates the
// encoding inputs to the internal result and the result to the outputs.
module ea_checker #(
    parameter int XLEN    = 64,
    parameter int CLEN    = 32,
    parameter bit OUT_REG = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            long_mode,
    input logic [7:0]      modrm,
    input logic [XLEN-1:0] ea_nxt,
    input logic            rip_nxt,
    input logic [1:0]      dsz_nxt,
    input logic            reg_nxt,
    input logic [XLEN-1:0] ea,
    input logic            rip_rel,
    input logic [1:0]      disp_size
);

    assert_regop_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (modrm[7:6] == 2'b11) |-> (ea_nxt == '0 && !rip_nxt && dsz_nxt == 2'd0 && reg_nxt));

    assert_rip_encoding_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rip_nxt |-> (long_mode && modrm[7:6] == 2'b00 && modrm[2:0] == 3'b101));

    assert_compat_no_rip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !long_mode |-> !rip_nxt);

    assert_compat_trunc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !long_mode |-> (ea_nxt[XLEN-1:CLEN] == '0));

    assert_dsz_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dsz_nxt != 2'd3);

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (OUT_REG && $past(rst_n)) |-> (ea == $past(ea_nxt) && rip_rel == $past(rip_nxt)
                                      && disp_size == $past(dsz_nxt)));

endmodule

bind ea_gen ea_checker #(.XLEN(XLEN), .CLEN(CLEN), .OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .long_mode (long_mode),
    .modrm     (modrm),
    .ea_nxt    (ea_nxt),
    .rip_nxt   (rip_nxt),
    .dsz_nxt   (dsz_nxt),
    .reg_nxt   (reg_nxt),
    .ea        (ea),
    .rip_rel   (rip_rel),
    .disp_size (disp_size)
);

// File: tb/tb_ea_gen.sv
// tb_ea_gen: seeded random plus directed bench for ea_gen (OUT_REG=1).
module tb_ea_gen;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          long_mode = 1'b0;
    logic          rex_b = 1'b0;
    logic          rex_x = 1'b0;
    logic [7:0]    modrm = '0;
    logic [7:0]    sib = '0;
    logic [31:0]   disp = '0;
    logic [63:0]   next_ip = '0;
    logic [1023:0] regs_flat;
    logic [63:0]   ea;
    logic          rip_rel;
    logic [1:0]    disp_size;
    logic          reg_operand;

    logic [63:0] rv [16];
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 16; i++) regs_flat[i*64 +: 64] = rv[i];
    end

    ea_gen dut (
        .clk(clk), .rst_n(rst_n), .long_mode(long_mode), .rex_b(rex_b), .rex_x(rex_x),
        .modrm(modrm), .sib(sib), .disp(disp), .next_ip(next_ip), .regs_flat(regs_flat),
        .ea(ea), .rip_rel(rip_rel), .disp_size(disp_size), .reg_operand(reg_operand)
    );

    // Reference address from the requirement text.
    function automatic logic [63:0] ref_ea(input logic [7:0] m, input logic [7:0] s,
                                           input logic b, input logic x, input logic lm,
                                           input logic [31:0] d, input logic [63:0] nip);
        logic [63:0] base, idx, dv, r;
        logic [3:0]  ic;
        if (!lm) begin b = 0; x = 0; end
        if (m[7:6] == 2'b11) return 64'd0;
        base = 0; idx = 0;
        dv = (m[7:6] == 2'b01) ? {{56{d[7]}}, d[7:0]} :
             (m[7:6] == 2'b10) ? {{32{d[31]}}, d} : 64'd0;
        if (m[2:0] == 3'b100) begin
            if (m[7:6] == 2'b00 && s[2:0] == 3'b101) dv = {{32{d[31]}}, d};
            else base = rv[{b, s[2:0]}];
            ic = {x, s[5:3]};
            if (ic != 4'b0100) idx = rv[ic] << s[7:6];
        end else if (m[7:6] == 2'b00 && m[2:0] == 3'b101) begin
            dv = {{32{d[31]}}, d};
            base = lm ? nip : 64'd0;
        end else base = rv[{b, m[2:0]}];
        r = base + idx + dv;
        if (!lm) r[63:32] = 0;
        return r;
    endfunction

    function automatic logic [1:0] ref_dsz(input logic [7:0] m, input logic [7:0] s);
        if (m[7:6] == 2'b01) return 2'd1;
        if (m[7:6] == 2'b10) return 2'd2;
        if (m[7:6] == 2'b00 && m[2:0] == 3'b101) return 2'd2;
        if (m[7:6] == 2'b00 && m[2:0] == 3'b100 && s[2:0] == 3'b101) return 2'd2;
        return 2'd0;
    endfunction

    task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive on falling edge, sample 5 ns after the capturing edge.
    task automatic apply(input logic [7:0] m, input logic [7:0] s, input logic b,
                         input logic x, input logic lm, input logic [31:0] d,
                         input logic [63:0] nip);
        @(negedge clk);
        modrm = m; sib = s; rex_b = b; rex_x = x; long_mode = lm; disp = d; next_ip = nip;
        @(posedge clk);
        #5;
    endtask

    task automatic run(input string tag, input logic [7:0] m, input logic [7:0] s,
                       input logic b, input logic x, input logic lm, input logic [31:0] d,
                       input logic [63:0] nip);
        logic exp_rip;
        apply(m, s, b, x, lm, d, nip);
        exp_rip = lm && m[7:6] == 2'b00 && m[2:0] == 3'b101;
        chk64({tag, " ea"}, ea, ref_ea(m, s, b, x, lm, d, nip));
        chk64({tag, " rip_rel"}, {63'd0, rip_rel}, {63'd0, exp_rip});
        chk64({tag, " disp_size"}, {62'd0, disp_size}, {62'd0, ref_dsz(m, s)});
        chk64({tag, " reg_operand"}, {63'd0, reg_operand}, {63'd0, m[7:6] == 2'b11});
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 16; i++) rv[i] = {$urandom, $urandom};
        modrm = 8'h85; disp = 32'h1234;
        repeat (3) @(posedge clk);
        #5;
        // R1: reset clears outputs
        chk64("R1 ea", ea, 64'd0);
        chk64("R1 flags", {61'd0, rip_rel, disp_size}, 64'd0);
        @(negedge clk) rst_n = 1'b1;

        run("R2 mod11", 8'hC3, 8'h00, 1, 1, 1, 32'hFFFF_FFFF, 64'h10);
        run("R3 disp8 neg", 8'h41, 8'h00, 0, 0, 1, 32'h0000_0080, 64'h0);
        run("R3 disp32 neg", 8'h82, 8'h00, 1, 0, 1, 32'h8000_0000, 64'h0);
        run("R3 no disp", 8'h07, 8'h00, 1, 0, 1, 32'hDEAD_BEEF, 64'h0);
        run("R4 sib scale8", 8'h44, 8'hC8, 0, 0, 1, 32'h10, 64'h0);
        run("R4 no index", 8'h04, 8'h63, 0, 0, 1, 32'h0, 64'h0);
        run("R4 index r12", 8'h04, 8'h63, 0, 1, 1, 32'h0, 64'h0);
        run("R5 nobase long", 8'h04, 8'h25, 1, 0, 1, 32'hFFFF_FFF0, 64'h1000);
        run("R5 nobase compat", 8'h04, 8'h25, 0, 0, 0, 32'h7000_0000, 64'h1000);
        run("R6 rip pos", 8'h05, 8'h00, 0, 0, 1, 32'h7FFF_FFFF, 64'h0000_0001_0000_0000);
        run("R6 rip neg", 8'h05, 8'h00, 0, 0, 1, 32'h8000_0000, 64'h0000_0001_0000_0000);
        run("R7 compat abs", 8'h05, 8'h00, 0, 0, 0, 32'h8000_0000, 64'hFFFF_0000);
        run("R8 compat rex ignored", 8'h81, 8'h00, 1, 1, 0, 32'hFFFF_FFFF, 64'h0);
        rv[15] = 64'hFFFF_FFFF_FFFF_FFF0;
        run("R9 wrap", 8'h47, 8'h00, 1, 0, 1, 32'h20, 64'h0);

        // R10: output holds until the next capturing edge
        @(negedge clk);
        modrm = 8'hC0;
        #3;
        chk64("R10 hold", ea, ref_ea(8'h47, 8'h00, 1, 0, 1, 32'h20, 64'h0));
        @(posedge clk);
        #5;
        chk64("R10 update", ea, 64'd0);

        for (int n = 0; n < 400; n++) begin
            if (n % 50 == 0) for (int i = 0; i < 16; i++) rv[i] = {$urandom, $urandom};
            run("R9 random", 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), $urandom, {$urandom, $urandom});
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule